// File: doc/BRIEF.md
# Nibble-Multiplexed Register Loader

This block drives four 8-bit output registers from one 8-bit port and adds no other signal lines. Each byte written to the port carries a 4-bit data nibble and 4 control bits. Two nibble writes build a full byte in a staging register, one write for the lower half and one for the upper half. A further write with the load bit set copies the staging byte into one of the four destination registers, chosen by a 2-bit address.

A host sends a short sequence of port writes for each register update: a low nibble, a high nibble, then a load command. A load happens only when the load bit changes from 0 to 1 between two consecutive port writes. Repeating a byte that already has the load bit set does nothing. Between port writes the port value is ignored.

Top module: `nml_loader`

## Requirements
- R1: Synchronous active-low reset clears the staging byte and all four destination registers to 0x00 and clears the remembered load bit, so that the first write with bit 7 set after reset performs a load.
- R2: A port write with bit 7 = 0 and bit 6 = 0 stores bits [3:0] into staging bits [3:0] and leaves staging bits [7:4] unchanged. Bits [5:4] have no effect on this.
- R3: A port write with bit 7 = 0 and bit 6 = 1 stores bits [3:0] into staging bits [7:4] and leaves staging bits [3:0] unchanged.
- R4: A port write with bit 7 = 0 changes no destination register.
- R5: A port write with bit 7 = 1, when the previous port write had bit 7 = 0, copies the staging byte into the register selected by bits [5:4]: 00 selects A, 01 selects B, 10 selects C and 11 selects D. The other three registers keep their values.
- R6: A port write with bit 7 = 1 leaves the staging byte unchanged.
- R7: A port write with bit 7 = 1, when the previous port write also had bit 7 = 1, changes no destination register, whatever its address bits are.
- R8: In a cycle without a port-write pulse, neither the staging byte nor any destination register changes, whatever the port value is.
- R9: The remembered load bit changes only on port writes, so port values present between writes never re-arm a load.
- R10: Every output is registered and shows a port write's effect from the clock edge that samples the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_data | input | 8 | Command byte: [3:0] nibble, [5:4] address, [6] upper-half select, [7] load bit |
| port_wr | input | 1 | One-cycle pulse marking a new port byte |
| reg_a | output | 8 | Destination register, address 00 |
| reg_b | output | 8 | Destination register, address 01 |
| reg_c | output | 8 | Destination register, address 10 |
| reg_d | output | 8 | Destination register, address 11 |
| stage_byte | output | 8 | Staging register contents |

## Verification
On every cycle the assertions check the following. No more than one destination is loaded at a time. Idle cycles and load commands leave the staging byte alone. Nibble writes leave every destination alone. Reset clears all outputs. Only the bench's scenarios can show that the correct half and the correct register receive data, and that a repeated load byte is ignored. They also show that idle port values between writes do not re-arm the load bit and that reset clears that remembered bit. The bench compares every output against a behavioural model on every clock.

// File: rtl/nml_pkg.sv
// Package: shared widths and the command byte layout for the nibble loader.
// Assumes an 8-bit command: nibble in the low bits, control bits above it.
package nml_pkg;
    localparam int NIB_W   = 4;
    localparam int ADDR_W  = 2;
    localparam int BYTE_W  = 2 * NIB_W;
    localparam int NUM_DST = 1 << ADDR_W;

    typedef struct packed {
        logic              load;    // bit 7: load strobe
        logic              hi_sel;  // bit 6: 1 = upper nibble
        logic [ADDR_W-1:0] addr;    // bits 5:4: destination
        logic [NIB_W-1:0]  nib;     // bits 3:0: data
    } cmd_t;
endpackage

// File: rtl/nml_decode.sv
// Decoder: turns each port write into nibble write enables or a one-hot
// destination load. Remembers the load bit of the previous write so a load
// fires only on its 0-to-1 change. Assumes port_wr is a one-cycle pulse.
module nml_decode
    import nml_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_wr,
    input  cmd_t               cmd,
    output logic               we_lo,
    output logic               we_hi,
    output logic [NUM_DST-1:0] load_sel
);
    logic armed_q;  // load bit of the previous port write

    // Purpose: track the last written load bit, updated only by port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (port_wr) armed_q <= cmd.load;
    end

    // Purpose: derive nibble enables and the addressed load line.
    always_comb begin
        we_lo    = port_wr && !cmd.load && !cmd.hi_sel;
        we_hi    = port_wr && !cmd.load &&  cmd.hi_sel;
        load_sel = '0;
        if (port_wr && cmd.load && !armed_q)
            load_sel[cmd.addr] = 1'b1;
    end

    assert_onehot_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_sel));
endmodule

// File: rtl/nml_stage.sv
// Staging register: assembles a byte from two nibble writes.
// Assumes at most one of the two enables is high in a cycle.
module nml_stage
    import nml_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [NIB_W-1:0]  nib,
    output logic [BYTE_W-1:0] stage_q
);
    // Purpose: write the selected half and hold the other.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (we_lo) stage_q[NIB_W-1:0]      <= nib;
        else if (we_hi) stage_q[BYTE_W-1:NIB_W] <= nib;
    end

    assert_stage_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_lo && !we_hi) |=> $stable(stage_q));
endmodule

// File: rtl/nml_bank.sv
// Destination bank: NUM_DST byte registers, each loaded from the staging
// byte when its select line is high. Assumes a one-hot-or-zero select.
module nml_bank
    import nml_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_DST-1:0]             load_sel,
    input  logic [BYTE_W-1:0]              din,
    output logic [NUM_DST-1:0][BYTE_W-1:0] dq
);
    for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
        // Purpose: hold one destination, reload on its select.
        always_ff @(posedge clk) begin
            if (!rst_n)           dq[g] <= '0;
            else if (load_sel[g]) dq[g] <= din;
        end

        assert_dst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !load_sel[g] |=> $stable(dq[g]));
    end
endmodule

// File: rtl/nml_loader.sv
// Top: loads four byte registers through one 8-bit port using nibble
// writes and a load command. Assumes port_data is valid while port_wr is high.
module nml_loader
    import nml_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] port_data,
    input  logic       port_wr,
    output logic [7:0] reg_a,
    output logic [7:0] reg_b,
    output logic [7:0] reg_c,
    output logic [7:0] reg_d,
    output logic [7:0] stage_byte
);
    cmd_t                           cmd;
    logic                           we_lo, we_hi;
    logic [NUM_DST-1:0]             load_sel;
    logic [NUM_DST-1:0][BYTE_W-1:0] dq;

    assign cmd = cmd_t'(port_data);

    nml_decode u_dec (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .cmd(cmd),
        .we_lo(we_lo), .we_hi(we_hi), .load_sel(load_sel)
    );

    nml_stage u_stage (
        .clk(clk), .rst_n(rst_n), .we_lo(we_lo), .we_hi(we_hi),
        .nib(cmd.nib), .stage_q(stage_byte)
    );

    nml_bank u_bank (
        .clk(clk), .rst_n(rst_n), .load_sel(load_sel),
        .din(stage_byte), .dq(dq)
    );

    assign reg_a = dq[0];
    assign reg_b = dq[1];
    assign reg_c = dq[2];
    assign reg_d = dq[3];

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stage_byte == 8'h00 && reg_a == 8'h00 && reg_b == 8'h00
                    && reg_c == 8'h00 && reg_d == 8'h00));

    assert_load_keeps_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_data[7]) |=> $stable(stage_byte));

    assert_nibble_no_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !port_data[7]) |=> ($stable(reg_a) && $stable(reg_b)
                                        && $stable(reg_c) && $stable(reg_d)));
endmodule

// File: tb/test_nml_loader.sv
module test_nml_loader;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] port_data = 8'h00;
    logic       port_wr = 0;
    logic [7:0] reg_a, reg_b, reg_c, reg_d, stage_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit compare_on = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_stage;
    int m_dst [4];
    bit m_prev;

    always #10 clk = ~clk;  // 50 MHz

    nml_loader i_nml_loader (
        .clk(clk), .rst_n(rst_n), .port_data(port_data), .port_wr(port_wr),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
        .stage_byte(stage_byte)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0;
            foreach (m_dst[i]) m_dst[i] = 0;
            m_prev = 0;
        end else if (port_wr) begin
            if (port_data[7]) begin
                if (!m_prev) m_dst[(port_data >> 4) % 4] = m_stage;
            end else if (port_data[6]) begin
                m_stage = (m_stage % 16) + 16 * (port_data % 16);
            end else begin
                m_stage = (m_stage / 16) * 16 + (port_data % 16);
            end
            m_prev = port_data[7];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (compare_on) begin
        chk(cur_req, stage_byte, m_stage);
        chk(cur_req, reg_a, m_dst[0]);
        chk(cur_req, reg_b, m_dst[1]);
        chk(cur_req, reg_c, m_dst[2]);
        chk(cur_req, reg_d, m_dst[3]);
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        port_data = b;
        port_wr = 1;
        @(negedge clk);
        port_wr = 0;
    endtask

    task automatic idle(input logic [7:0] b, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            port_data = b;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_on = 1;
        @(negedge clk);
        chk("R1", {reg_a, reg_b, reg_c, reg_d, stage_byte}, 0);

        cur_req = "R2"; wr(8'h0A);
        chk("R2 R10", stage_byte, 8'h0A);
        cur_req = "R3"; wr(8'h45);
        chk("R3", stage_byte, 8'h5A);
        chk("R4", reg_a, 8'h00);
        cur_req = "R5"; wr(8'h80);
        chk("R5 A", reg_a, 8'h5A);
        chk("R6", stage_byte, 8'h5A);
        cur_req = "R7"; wr(8'h90);
        chk("R7", reg_b, 8'h00);
        cur_req = "R5"; wr(8'h03); wr(8'h41);
        chk("R3", stage_byte, 8'h13);
        wr(8'hB0);
        chk("R5 D", reg_d, 8'h13);
        wr(8'h0F); wr(8'hE0);
        chk("R5 C", reg_c, 8'h1F);
        chk("R5 others", reg_a, 8'h5A);
        cur_req = "R8"; idle(8'h8F, 4); idle(8'h5C, 2);
        @(negedge clk);
        chk("R8", stage_byte, 8'h1F);
        chk("R8", reg_a, 8'h5A);
        cur_req = "R2"; wr(8'h27);
        chk("R2 addr ignored", stage_byte, 8'h17);
        chk("R4", reg_c, 8'h1F);
        cur_req = "R5"; wr(8'h90);
        chk("R5 B", reg_b, 8'h17);
        cur_req = "R9"; idle(8'h00, 3); wr(8'hA0);
        chk("R9", reg_c, 8'h1F);
        cur_req = "R1";
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R1", {reg_a, reg_b, reg_c, reg_d, stage_byte}, 0);
        wr(8'h46); wr(8'hF0);
        chk("R1 strobe cleared", reg_d, 8'h60);
        @(negedge clk);
        compare_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule